// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one page table entry from memory. Each request carries an access kind: read, write or execute. The walker first compares the virtual page number with a page-count limit register. If the page is inside the limit, it forms the entry address from a per-context base register and issues a single-word read on a simple request/acknowledge memory port.

When the entry arrives, the walker checks it in this order: present bit, then permission bit for the access kind. If both pass, it returns the physical page number joined to the untouched page offset. On a successful access it sets the reference bit in the entry, and on a write it also sets the dirty bit. The updated entry goes back to the same memory word, but only when one of those two bits actually changes.

The walker serves one request at a time and holds `busy` high from acceptance until the cycle in which it reports the result. Loading the base register, for example on a context switch, redirects every request accepted afterwards to a different table.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are all low.
- R2: The entry is read from byte address base + (vaddr[31:12] × 4). The base value used is the one held when the request is accepted.
- R3: If vaddr[31:12] is greater than or equal to the limit register, the result is a fault with `fault_code` = 1 and no memory access is made.
- R4: An entry with bit 0 (present) clear gives a fault with `fault_code` = 2. This check takes priority over the permission check.
- R5: Access kind 0 (read) needs entry bit 1, kind 1 (write) needs bit 2, and kind 2 (execute) needs bit 3. Kind 3 is never allowed. A missing permission gives a fault with `fault_code` = 3.
- R6: On success, `fault` is low and `paddr` = {entry[31:12], vaddr[11:0]}.
- R7: On success, entry bit 4 (reference) is set, and on a write entry bit 5 (dirty) is also set. The entry is written back to the same address only when this changes its value.
- R8: A faulting request writes nothing to memory.
- R9: After a new base value is loaded, later translations of the same virtual address use the new table.
- R10: `busy` is high from the cycle after acceptance through the cycle in which `done` is high. `req_valid` is ignored while `busy` is high.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R12: `done` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 32 | New table base byte address |
| limit_we | input | 1 | Load the page-count limit register |
| limit_wdata | input | 20 | New limit, in pages |
| req_valid | input | 1 | Translation request, taken when idle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Result valid this cycle |
| fault | output | 1 | The request failed |
| fault_code | output | 2 | 1 limit, 2 not present, 3 protection |
| paddr | output | 32 | Physical address on success |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Entry read data, valid with `mem_ack` |

## Verification
The bench builds the walker with its default 32-bit address, 4 KB pages and 4-byte entries. It places tables at two base addresses inside a 4 KB model memory, so a base reload can be seen to change the returned physical page. The limit register is loaded with small page counts, which puts both sides of the limit boundary within reach. The model memory inserts a wait cycle before each acknowledge, so the port's hold rule is exercised on every access.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W      = 32,
  parameter int OFS_W     = 12,
  parameter int PTE_SHIFT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  base_we,
  input  logic [VA_W-1:0]       base_wdata,
  input  logic                  limit_we,
  input  logic [VA_W-OFS_W-1:0] limit_wdata,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_kind,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output logic [1:0]            fault_code,
  output logic [VA_W-1:0]       paddr,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [VA_W-1:0]       mem_addr,
  output logic [VA_W-1:0]       mem_wdata,
  input  logic                  mem_ack,
  input  logic [VA_W-1:0]       mem_rdata
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PAD_W = VA_W - VPN_W - PTE_SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_RESP} st_t;
  st_t st;

  logic [VA_W-1:0]  base_q, addr_q, pte_q;
  logic [VPN_W-1:0] limit_q;
  logic [OFS_W-1:0] ofs_q;
  logic [1:0]       kind_q, code_q;

  wire [VPN_W-1:0] vpn = req_vaddr[VA_W-1:OFS_W];

  logic allowed;
  always_comb begin
    case (kind_q)
      2'd0:    allowed = mem_rdata[1];
      2'd1:    allowed = mem_rdata[2];
      2'd2:    allowed = mem_rdata[3];
      default: allowed = 1'b0;
    endcase
  end

  wire [VA_W-1:0] upd = mem_rdata | (VA_W'(1) << 4) | (VA_W'(kind_q == 2'd1) << 5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      limit_q <= '0;
      addr_q  <= '0;
      pte_q   <= '0;
      ofs_q   <= '0;
      kind_q  <= '0;
      code_q  <= '0;
    end else begin
      if (base_we)  base_q  <= base_wdata;
      if (limit_we) limit_q <= limit_wdata;
      case (st)
        S_IDLE: if (req_valid) begin
          ofs_q  <= req_vaddr[OFS_W-1:0];
          kind_q <= req_kind;
          addr_q <= base_q + {{PAD_W{1'b0}}, vpn, {PTE_SHIFT{1'b0}}};
          if (vpn >= limit_q) begin
            code_q <= 2'd1;
            st     <= S_RESP;
          end else begin
            code_q <= 2'd0;
            st     <= S_READ;
          end
        end
        S_READ: if (mem_ack) begin
          pte_q <= upd;
          if (!mem_rdata[0]) begin
            code_q <= 2'd2;
            st     <= S_RESP;
          end else if (!allowed) begin
            code_q <= 2'd3;
            st     <= S_RESP;
          end else if (upd != mem_rdata) begin
            st <= S_WRITE;
          end else begin
            st <= S_RESP;
          end
        end
        S_WRITE: if (mem_ack) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = st != S_IDLE;
  assign done       = st == S_RESP;
  assign fault      = done && code_q != 2'd0;
  assign fault_code = done ? code_q : 2'd0;
  assign paddr      = {pte_q[VA_W-1:OFS_W], ofs_q};
  assign mem_req    = st == S_READ || st == S_WRITE;
  assign mem_we     = st == S_WRITE;
  assign mem_addr   = addr_q;
  assign mem_wdata  = pte_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic            mem_req,
  input logic            mem_we,
  input logic [VA_W-1:0] mem_addr,
  input logic [VA_W-1:0] mem_wdata,
  input logic            mem_ack
);
  assert_mem_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_wb_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[4] && mem_wdata[0]));

  assert_fault_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && !mem_req));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic clk = 0, rst_n = 0;
  logic base_we = 0, limit_we = 0, req_valid = 0;
  logic [31:0] base_wdata = 0, req_vaddr = 0;
  logic [19:0] limit_wdata = 0;
  logic [1:0]  req_kind = 0;
  logic busy, done, fault, mem_req, mem_we;
  logic [1:0]  fault_code;
  logic [31:0] paddr, mem_addr, mem_wdata;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = 0;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd, hold_addr;
  logic wt = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] cur_base = 0;
  logic [19:0] cur_lim = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .limit_we(limit_we), .limit_wdata(limit_wdata), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .busy(busy), .done(done),
    .fault(fault), .fault_code(fault_code), .paddr(paddr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; wt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 0;
    end else if (mem_req && !wt) begin
      wt <= 1; hold_addr <= mem_addr;
    end else if (mem_req && wt) begin
      chk(mem_addr == hold_addr, "R11 address hold", mem_addr, hold_addr);
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        last_rd <= mem_addr;
        rd_cnt = rd_cnt + 1;
      end
      mem_ack <= 1; wt <= 0;
    end
  end

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); base_we = 1; base_wdata = b;
    @(negedge clk); base_we = 0; cur_base = b;
  endtask

  task automatic set_lim(input logic [19:0] l);
    @(negedge clk); limit_we = 1; limit_wdata = l;
    @(negedge clk); limit_we = 0; cur_lim = l;
  endtask

  task automatic tr(input logic [31:0] va, input logic [1:0] ty, input string rq, input bit poke = 0);
    logic [19:0] vpn;
    logic [31:0] ea, pte, npte;
    logic [1:0]  ecode;
    bit perm;
    int rd0, wr0, n;
    vpn = va[31:12];
    ea = cur_base + {10'd0, vpn, 2'b00};
    pte = mem[ea[11:2]];
    perm = (ty == 0) ? pte[1] : (ty == 1) ? pte[2] : (ty == 2) ? pte[3] : 1'b0;
    if (vpn >= cur_lim) ecode = 1;
    else if (!pte[0]) ecode = 2;
    else if (!perm) ecode = 3;
    else ecode = 0;
    npte = pte | 32'h10 | ((ty == 1) ? 32'h20 : 32'h0);
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk); req_valid = 1; req_vaddr = va; req_kind = ty;
    @(negedge clk); req_valid = 0;
    n = 0;
    while (!done && n < 100) begin
      chk(busy == 1, {rq, " R10 busy"}, busy, 1);
      if (poke && n == 1) begin req_valid = 1; req_vaddr = 32'h0000_1abc; req_kind = 0; end
      else req_valid = 0;
      @(negedge clk); n++;
    end
    req_valid = 0;
    chk(done == 1, {rq, " R12 done"}, done, 1);
    chk(fault == (ecode != 0), {rq, " fault"}, fault, ecode != 0);
    chk(fault_code == ecode, {rq, " fault_code"}, fault_code, ecode);
    if (ecode == 0) chk(paddr == {pte[31:12], va[11:0]}, {rq, " R6 paddr"}, paddr, {pte[31:12], va[11:0]});
    if (ecode == 1) chk(rd_cnt == rd0, {rq, " R3 no read"}, rd_cnt, rd0);
    else begin
      chk(rd_cnt == rd0 + 1, {rq, " R2 one read"}, rd_cnt, rd0 + 1);
      chk(last_rd == ea, {rq, " R2 entry address"}, last_rd, ea);
    end
    if (ecode == 0 && npte != pte) begin
      chk(wr_cnt == wr0 + 1, {rq, " R7 writeback"}, wr_cnt, wr0 + 1);
      chk(mem[ea[11:2]] == npte, {rq, " R7 entry bits"}, mem[ea[11:2]], npte);
    end else
      chk(wr_cnt == wr0, {rq, " R7 R8 no write"}, wr_cnt, wr0);
    @(negedge clk);
    chk(done == 0, {rq, " R12 single pulse"}, done, 0);
    chk(busy == 0, {rq, " R10 idle after"}, busy, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    // table A at 0x400, table B at 0x800
    mem[256 + 0] = 32'h0001_1003; // read only, present
    mem[256 + 1] = 32'h0002_2007; // read+write
    mem[256 + 2] = 32'h0003_3002; // not present
    mem[256 + 3] = 32'h0004_4009; // exec only
    mem[256 + 4] = 32'h0005_5013; // read, ref already set
    mem[256 + 5] = 32'h0006_600F; // all perms
    mem[512 + 0] = 32'h0007_7003;
    mem[512 + 1] = 32'h0008_8003;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fault == 0 && mem_req == 0, "R1 reset outputs",
        {busy, done, fault, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    set_base(32'h400);
    set_lim(20'd6);
    tr(32'h0000_0123, 0, "R6 R7 read sets ref");
    tr(32'h0000_0123, 0, "R7 repeat read unchanged");
    tr(32'h0000_0fff, 1, "R5 write without perm");
    tr(32'h0000_1456, 1, "R7 write sets dirty");
    tr(32'h0000_2000, 0, "R4 not present");
    tr(32'h0000_3abc, 2, "R5 exec allowed");
    tr(32'h0000_3abc, 0, "R5 read on exec only");
    tr(32'h0000_4010, 0, "R7 ref already set");
    tr(32'h0000_5555, 3, "R5 reserved kind");
    tr(32'h0000_5555, 2, "R3 limit minus one");
    tr(32'h0000_6000, 0, "R3 at limit");
    tr(32'hfff0_0000, 1, "R3 far beyond limit");
    tr(32'h0000_0777, 0, "R10 request ignored while busy", 1);
    set_base(32'h800);
    tr(32'h0000_0321, 0, "R9 new base page 0");
    tr(32'h0000_1321, 0, "R9 new base page 1");
    set_lim(20'd0);
    tr(32'h0000_0000, 0, "R3 zero limit");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule